// File: doc/BRIEF.md
# Conditional ALU with Bit Operations

This block is a single-cycle, 16-bit fixed-point ALU stage for a small signal-processing datapath. Each issued operation combines an X operand with a Y operand. The Y operand is a register value, a constant chosen by a 5-bit code from a restricted set, or zero. The stage performs add, add with carry, the two subtraction directions with and without borrow, AND, OR, XOR and pass. It also performs test, set, clear and toggle of one selected bit. Each bit operation is built by feeding a generated mask into the logic unit.

Every operation is predicated on a condition code, which is evaluated against the registered status flags before the operation takes effect. When the condition fails, the operation does nothing. When it holds, the result is written into one of two result registers and the flags are refreshed. A result-free mode refreshes only the flags and leaves both result registers untouched. Multiply, shift and divide steps are handled elsewhere.

Top module: `cond_alu`

## Requirements
- R1: While `rst_n` is low and for the cycles needed to release the internal reset, `res_a`, `res_b` and all four flags read 0.
- R2: Arithmetic op codes are 0 X+Y, 1 X+Y+C, 2 X−Y, 3 X+~Y+C, 4 Y−X and 5 Y+~X+C. C is the carry out of bit 15, where 1 means no borrow for the subtracting forms. V is two's-complement overflow. Z is set when the 16-bit result is zero, and N is bit 15 of the result.
- R3: Logic op codes are 6 AND, 7 OR, 8 XOR and 9 PASS, which copies Y; codes 14 and 15 act as PASS. These ops set Z and N from the result and clear C and V. A PASS of zero writes 0 to the destination.
- R4: The bit ops ignore the Y source and use a mask built from `bit_idx`, where index 0 is the LSB. Code 10 is X AND the one-hot mask (test), 11 is X OR the one-hot mask (set), 12 is X AND the inverted one-hot mask (clear), and 13 is X XOR the one-hot mask (toggle).
- R5: `y_src` 0 selects `y_op`, 1 selects the constant, and 2 or 3 select zero. For `imm_code` k, codes 0..14 give 2^k, 15 gives 0x7FFF, 16..30 give the bitwise complement of 2^(k−16), and 31 gives 0x8000.
- R6: `dest_sel` 0 writes `res_a` and 1 writes `res_b`. The other result register keeps its value.
- R7: Condition codes are 0 always, 1 EQ (Z), 2 NE (!Z), 3 GT (!(N^V) and !Z), 4 GE (!(N^V)), 5 LT (N^V), 6 LE ((N^V) or Z) and 7 carry set (C). Each is evaluated on the flags registered before the operation.
- R8: When the condition is false, both result registers and all flags are unchanged at the next edge.
- R9: With `result_free` high and the condition true, the flags take the computed values and both result registers keep their previous contents.
- R10: With `issue` low, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Function select |
| cond_code | input | 3 | Predicate on the registered flags |
| x_op | input | 16 | X operand |
| y_op | input | 16 | Y register operand |
| y_src | input | 2 | Y source select |
| imm_code | input | 5 | Constant index |
| bit_idx | input | 4 | Bit index for bit ops |
| dest_sel | input | 1 | Result register select |
| result_free | input | 1 | Update flags only |
| res_a | output | 16 | Result register A |
| res_b | output | 16 | Result register B |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
On every cycle, the assertions check the hold behaviour. Nothing changes when `issue` is low or the predicate fails, the unselected result register and both registers in result-free mode keep their values, logic ops leave C and V clear, Z and N agree with the written A value, and the bit mask is one-hot. Only the bench's sweeps can show that the arithmetic values, carries and overflows, the constant table and each condition's decision are correct. They do so by comparing against figures computed with integer arithmetic across boundary operands, all bit indices, all constant codes and every condition under several flag states.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_RSB = 4'd4, OP_RSC = 4'd5, OP_AND = 4'd6, OP_OR  = 4'd7,
    OP_XOR = 4'd8, OP_PASS = 4'd9, OP_TST = 4'd10, OP_SET = 4'd11,
    OP_CLR = 4'd12, OP_TGL = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0, CC_EQ = 3'd1, CC_NE = 3'd2, CC_GT = 3'd3,
    CC_GE = 3'd4, CC_LT = 3'd5, CC_LE = 3'd6, CC_CS = 3'd7
  } cond_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  function automatic logic is_bit_op(alu_op_e op);
    return (op == OP_TST) || (op == OP_SET) || (op == OP_CLR) || (op == OP_TGL);
  endfunction

  function automatic logic is_arith_op(alu_op_e op);
    return op <= OP_RSC;
  endfunction

endpackage

// File: rtl/cond_alu_ysel.sv
module cond_alu_ysel
  import cond_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int IMW = $clog2(2 * W),
  localparam int BW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [1:0]     y_src,
  input  logic [W-1:0]   y_op,
  input  logic [IMW-1:0] imm_code,
  input  logic [BW-1:0]  bit_idx,
  output logic [W-1:0]   y_eff
);

  logic [W-1:0] imm_val;
  logic [W-1:0] onehot;

  // constant set: powers of two, their complements, and the two extremes
  always_comb begin
    if (imm_code < IMW'(W - 1))
      imm_val = W'(1) << imm_code;
    else if (imm_code == IMW'(W - 1))
      imm_val = {1'b0, {(W-1){1'b1}}};
    else if (imm_code < IMW'(2 * W - 1))
      imm_val = ~(W'(1) << (imm_code - IMW'(W)));
    else
      imm_val = {1'b1, {(W-1){1'b0}}};
  end

  assign onehot = W'(1) << bit_idx;

  always_comb begin
    if (is_bit_op(op))
      y_eff = (op == OP_CLR) ? ~onehot : onehot;
    else begin
      unique case (y_src)
        2'd0:    y_eff = y_op;
        2'd1:    y_eff = imm_val;
        default: y_eff = '0;
      endcase
    end
  end

  // R4: the bit mask selects exactly one bit
  always_comb begin
    if (!$isunknown(bit_idx))
      p_mask_onehot_r4: assert ($countones(onehot) == 1);
  end

endmodule

// File: rtl/cond_alu_core.sv
module cond_alu_core
  import cond_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] res,
  output flags_t       fl
);

  logic [W-1:0] opa, opb;
  logic         ci;
  logic [W:0]   sum;
  logic [W-1:0] lres;
  logic         arith;

  // one adder serves all six arithmetic forms by swapping and inverting inputs
  always_comb begin
    opa = x;
    opb = y;
    ci  = 1'b0;
    unique case (op)
      OP_ADC:  ci = cin;
      OP_SUB:  begin opb = ~y; ci = 1'b1; end
      OP_SBB:  begin opb = ~y; ci = cin;  end
      OP_RSB:  begin opa = y; opb = ~x; ci = 1'b1; end
      OP_RSC:  begin opa = y; opb = ~x; ci = cin;  end
      default: ;
    endcase
  end

  assign sum   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
  assign arith = is_arith_op(op);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST, OP_CLR: lres = x & y;
      OP_OR,  OP_SET:         lres = x | y;
      OP_XOR, OP_TGL:         lres = x ^ y;
      default:                lres = y;
    endcase
  end

  assign res  = arith ? sum[W-1:0] : lres;
  assign fl.z = (res == '0);
  assign fl.n = res[W-1];
  assign fl.c = arith & sum[W];
  assign fl.v = arith & (opa[W-1] == opb[W-1]) & (res[W-1] != opa[W-1]);

endmodule

// File: rtl/cond_alu_cond.sv
module cond_alu_cond
  import cond_alu_pkg::*;
(
  input  cond_e  cc,
  input  flags_t fl,
  output logic   ok
);

  logic lt;
  assign lt = fl.n ^ fl.v;

  always_comb begin
    unique case (cc)
      CC_EQ:   ok = fl.z;
      CC_NE:   ok = ~fl.z;
      CC_GT:   ok = ~lt & ~fl.z;
      CC_GE:   ok = ~lt;
      CC_LT:   ok = lt;
      CC_LE:   ok = lt | fl.z;
      CC_CS:   ok = fl.c;
      default: ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int IMW = $clog2(2 * W),
  localparam int BW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [3:0]     op_code,
  input  logic [2:0]     cond_code,
  input  logic [W-1:0]   x_op,
  input  logic [W-1:0]   y_op,
  input  logic [1:0]     y_src,
  input  logic [IMW-1:0] imm_code,
  input  logic [BW-1:0]  bit_idx,
  input  logic           dest_sel,
  input  logic           result_free,
  output logic [W-1:0]   res_a,
  output logic [W-1:0]   res_b,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_c,
  output logic           flag_v
);

  logic [1:0]   rst_sync_q;
  logic         rst_q_n;
  alu_op_e      op;
  logic [W-1:0] y_eff;
  logic [W-1:0] res_new;
  flags_t       fl_new;
  flags_t       fl_q;
  logic         cond_ok;
  logic         exec;
  logic         en_a, en_b, en_f;
  logic [W-1:0] res_a_q, res_b_q;

  // reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign op = alu_op_e'(op_code);

  cond_alu_ysel #(.W(W)) u_ysel (
    .op(op), .y_src(y_src), .y_op(y_op), .imm_code(imm_code),
    .bit_idx(bit_idx), .y_eff(y_eff)
  );

  cond_alu_core #(.W(W)) u_core (
    .op(op), .x(x_op), .y(y_eff), .cin(fl_q.c), .res(res_new), .fl(fl_new)
  );

  cond_alu_cond u_cond (
    .cc(cond_e'(cond_code)), .fl(fl_q), .ok(cond_ok)
  );

  // next-state enables
  always_comb begin
    exec = issue & cond_ok;
    en_f = exec;
    en_a = exec & ~result_free & ~dest_sel;
    en_b = exec & ~result_free & dest_sel;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_a_q <= '0;
      res_b_q <= '0;
      fl_q    <= '0;
    end else begin
      if (en_a) res_a_q <= res_new;
      if (en_b) res_b_q <= res_new;
      if (en_f) fl_q    <= fl_new;
    end
  end

  assign res_a  = res_a_q;
  assign res_b  = res_b_q;
  assign flag_z = fl_q.z;
  assign flag_n = fl_q.n;
  assign flag_c = fl_q.c;
  assign flag_v = fl_q.v;

  // R10: idle cycle changes nothing
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !issue |=> $stable(res_a) && $stable(res_b) && $stable({flag_z, flag_n, flag_c, flag_v}));

  // R8: failed predicate changes nothing
  p_cond_false_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue && !cond_ok |=> $stable(res_a) && $stable(res_b) && $stable({flag_z, flag_n, flag_c, flag_v}));

  // R9: result-free keeps both result registers
  p_result_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue && result_free |=> $stable(res_a) && $stable(res_b));

  // R6: the unselected register holds
  p_dest_other_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue && !dest_sel |=> $stable(res_b));

  // R3: logic and bit ops leave carry and overflow clear
  p_logic_clears_cv_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue && cond_ok && (op_code >= 4'd6) |=> !flag_c && !flag_v);

  // R2: zero and sign flags agree with the value written to A
  p_flags_track_a_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue && cond_ok && !result_free && !dest_sel |=> (flag_z == (res_a == '0)) && (flag_n == res_a[W-1]));

endmodule

// File: tb/cond_alu_tb_top.sv
module cond_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [3:0]  op_code;
  logic [2:0]  cond_code;
  logic [15:0] x_op, y_op;
  logic [1:0]  y_src;
  logic [4:0]  imm_code;
  logic [3:0]  bit_idx;
  logic        dest_sel, result_free;
  logic [15:0] res_a, res_b;
  logic        flag_z, flag_n, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the architectural state
  int ma, mb;
  bit mz, mn, mc, mv;

  always #5 clk = ~clk;

  cond_alu dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .cond_code(cond_code), .x_op(x_op), .y_op(y_op), .y_src(y_src),
    .imm_code(imm_code), .bit_idx(bit_idx), .dest_sel(dest_sel),
    .result_free(result_free), .res_a(res_a), .res_b(res_b),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic int imm_of(int k);
    if (k < 15)       return 2 ** k;
    else if (k == 15) return 32767;
    else if (k < 31)  return 65535 - 2 ** (k - 16);
    else              return 32768;
  endfunction

  function automatic int sgn(int u);
    return (u >= 32768) ? u - 65536 : u;
  endfunction

  function automatic bit cond_true(int cc);
    case (cc)
      1: return mz;
      2: return !mz;
      3: return (mn == mv) && !mz;
      4: return mn == mv;
      5: return mn != mv;
      6: return (mn != mv) || mz;
      7: return mc;
      default: return 1'b1;
    endcase
  endfunction

  task automatic compare(string tag);
    logic [35:0] got, exp;
    got = {res_a, res_b, flag_z, flag_n, flag_c, flag_v};
    exp = {ma[15:0], mb[15:0], mz, mn, mc, mv};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h znc v=%b%b%b%b exp a=%h b=%h znc v=%b%b%b%b",
               tag, res_a, res_b, flag_z, flag_n, flag_c, flag_v,
               ma[15:0], mb[15:0], mz, mn, mc, mv);
    end
  endtask

  // called at a falling edge; drives, waits one edge, checks at the next falling edge
  task automatic run_op(bit iss, int op, int cc, int x, int y, int ys, int imm,
                        int bi, bit ds, bit rf, string tag);
    int yv, s, sv, r;
    bit c, v, ex;
    issue = iss; op_code = op[3:0]; cond_code = cc[2:0];
    x_op = x[15:0]; y_op = y[15:0]; y_src = ys[1:0];
    imm_code = imm[4:0]; bit_idx = bi[3:0]; dest_sel = ds; result_free = rf;
    ex = iss && cond_true(cc);
    if (op >= 10 && op <= 13) yv = (op == 12) ? 65535 - 2 ** bi : 2 ** bi;
    else if (ys == 0) yv = y;
    else if (ys == 1) yv = imm_of(imm);
    else yv = 0;
    c = 0; v = 0; s = 0; sv = 0;
    case (op)
      0: begin s = x + yv;                 sv = sgn(x) + sgn(yv); end
      1: begin s = x + yv + mc;            sv = sgn(x) + sgn(yv) + mc; end
      2: begin s = x + (65535 - yv) + 1;   sv = sgn(x) - sgn(yv); end
      3: begin s = x + (65535 - yv) + mc;  sv = sgn(x) - sgn(yv) - 1 + mc; end
      4: begin s = yv + (65535 - x) + 1;   sv = sgn(yv) - sgn(x); end
      5: begin s = yv + (65535 - x) + mc;  sv = sgn(yv) - sgn(x) - 1 + mc; end
      6, 10, 12: s = x & yv;
      7, 11:     s = x | yv;
      8, 13:     s = x ^ yv;
      default:   s = yv;
    endcase
    r = s % 65536;
    if (op <= 5) begin
      c = s > 65535;
      v = (sv > 32767) || (sv < -32768);
    end
    @(negedge clk);
    if (ex) begin
      mz = (r == 0); mn = r >= 32768; mc = c; mv = v;
      if (!rf) begin
        if (ds) mb = r; else ma = r;
      end
    end
    compare(tag);
  endtask

  initial begin
    int vals[8];
    vals = '{0, 1, 2, 32767, 32768, 32769, 65534, 65535};
    rst_n = 1'b0; issue = 0; op_code = 0; cond_code = 0; x_op = 0; y_op = 0;
    y_src = 0; imm_code = 0; bit_idx = 0; dest_sel = 0; result_free = 0;
    ma = 0; mb = 0; mz = 0; mn = 0; mc = 0; mv = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    // R10: idle cycles with live-looking inputs
    run_op(0, 0, 0, 1234, 77, 0, 0, 0, 0, 0, "R10 idle add");
    run_op(0, 9, 0, 0, 0, 0, 0, 0, 1, 0, "R10 idle pass");

    // R2 and R6: arithmetic sweep over boundary operands, both destinations
    for (int op = 0; op <= 5; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(1, op, 0, vals[i], vals[j], 0, 0, 0, ((i + j) % 2) == 1, 0,
                 "R2 arith sweep / R6 dest");

    // R3: logic and pass sweep, plus reserved codes acting as pass
    for (int op = 6; op <= 9; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(1, op, 0, vals[i], vals[j] ^ 16'h0F0F, 0, 0, 0, (j % 2) == 1, 0, "R3 logic sweep");
    run_op(1, 14, 0, 5, 16'h4321, 0, 0, 0, 0, 0, "R3 reserved code 14");
    run_op(1, 15, 0, 5, 16'h8001, 0, 0, 0, 1, 0, "R3 reserved code 15");
    run_op(1, 9, 0, 16'hFFFF, 16'hFFFF, 2, 0, 0, 0, 0, "R3 pass zero clears A");
    run_op(1, 9, 0, 16'hFFFF, 16'hFFFF, 3, 0, 0, 1, 0, "R3 pass zero clears B");

    // R4: every bit op, every index, Y source must not matter
    for (int op = 10; op <= 13; op++)
      for (int b = 0; b < 16; b++) begin
        run_op(1, op, 0, 16'h0000, 16'hFFFF, 1, 31, b, 0, 0, "R4 bit op on zeros");
        run_op(1, op, 0, 16'hFFFF, 16'h1234, 0, 3, b, 1, 0, "R4 bit op on ones");
        run_op(1, op, 0, 16'hA5C3, 16'h0000, 2, 7, b, b % 2 == 1, 0, "R4 bit op on pattern");
      end

    // R5: whole constant table through pass, then used as adder input
    for (int k = 0; k < 32; k++)
      run_op(1, 9, 0, 16'h5555, 16'hBEEF, 1, k, 0, k % 2 == 1, 0, "R5 constant table");
    for (int k = 0; k < 32; k += 5)
      run_op(1, 0, 0, 16'h7FF0, 16'hBEEF, 1, k, 0, 0, 0, "R5 constant add");

    // R7 and R8: each condition under several flag states
    for (int s = 0; s < 5; s++)
      for (int cc = 0; cc < 8; cc++) begin
        case (s)
          0: run_op(1, 2, 0, 5, 5, 0, 0, 0, 1, 0, "R7 set equal");
          1: run_op(1, 2, 0, 9, 3, 0, 0, 0, 1, 0, "R7 set greater");
          2: run_op(1, 2, 0, 3, 9, 0, 0, 0, 1, 0, "R7 set less");
          3: run_op(1, 2, 0, 32768, 1, 0, 0, 0, 1, 0, "R7 set overflow");
          default: run_op(1, 2, 0, 16'hFFFE, 16'hFFFF, 0, 0, 0, 1, 0, "R7 set borrow");
        endcase
        run_op(1, 9, cc, 0, 16'h1000 + cc + 16 * s, 0, 0, 0, 0, 0, "R7 R8 predicate on pass");
      end

    // R9: result-free keeps both registers
    run_op(1, 9, 0, 0, 16'h1111, 0, 0, 0, 0, 0, "R9 preload A");
    run_op(1, 9, 0, 0, 16'h2222, 0, 0, 0, 1, 0, "R9 preload B");
    for (int i = 0; i < 8; i++) begin
      run_op(1, 2, 0, vals[i], vals[7 - i], 0, 0, 0, i % 2 == 1, 1, "R9 result-free sub");
      run_op(1, 12, 0, vals[i], 0, 0, 0, i, 0, 1, "R9 result-free clear bit");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule